// File: doc/BRIEF.md
# Nonlinear Feedback Chip Sequence Generator

This block produces a binary spreading chip stream for a direct-sequence spread spectrum link. Its state is a cascade of four cells. Each cell is a pair of 8-bit registers: an upper register and a lower register. The cells pass bits to their neighbours in both directions. The XOR of each cell's register pair feeds forward as the next cell's upper value. The 8-bit value of the last cell is folded by parity into one chip per iteration, and that chip is fed back into both ends of the cascade. This makes the next-state function nonlinear, unlike a single-polynomial shift register.

Software or a control sequencer seeds the 64 state bits through a narrow load port. The port takes a 3-bit register index and an 8-bit value per cycle. A ready flag reports that all eight registers have been written in the current load session. Once seeded, the generator advances one iteration on every cycle in which the run input is high. It holds its state otherwise, so a transmitter and a receiver seeded alike produce the same chip stream in step.

Top module: `chaos_chip_gen`

## Requirements
- R1: A synchronous active-high reset clears all eight state registers, the ready flag, the chip output and the chip-valid flag.
- R2: While load_i is high, seed_i is written into the register chosen by sel_i. An even index 2c selects the upper register of cell c, and an odd index 2c+1 selects the lower register of cell c, with cells numbered 0 to 3 from the head of the cascade.
- R3: ready_o goes high one cycle after load_i falls, provided that all eight indices were written during that load session. A session in which fewer than eight distinct indices were written leaves ready_o low.
- R4: ready_o is low in every cycle that follows a cycle with load_i high. A new load session restarts the tracking of which registers have been written.
- R5: Load has priority over run. No iteration takes place in a cycle with load_i high, and chip_vld_o is low in the following cycle.
- R6: With run_i and load_i both low, the state, tap_o and chip_o hold their values, and chip_vld_o is low.
- R7: On an iteration, the upper register of cell c (c>0) takes the XOR of the upper and lower registers of cell c-1. The upper register of cell 0 shifts left by one, and the feedback chip enters at bit 0.
- R8: On an iteration, every lower register shifts left by one. The bit entering bit 0 of cell c is bit 7 of the lower register of cell c+1, and for cell 3 it is the feedback chip. Bit 7 leaving cell 0 is discarded.
- R9: On an iteration, the feedback chip is the parity (XOR of all 8 bits) of tap_o before the edge. That chip appears on chip_o after the edge, with chip_vld_o high for that one cycle. tap_o always shows the XOR of the last cell's upper and lower registers.
- R10: Seeds FE, FD, FC, FB, FA, F9, F8, F6 (hex, indices 0..7) and the same seeds with index 7 set to F7 produce chip streams that differ within 64 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Seed write strobe; overrides run_i |
| sel_i | input | 3 | Register index for the seed write |
| seed_i | input | 8 | Seed value to write |
| run_i | input | 1 | Advance one iteration per cycle |
| ready_o | output | 1 | All registers seeded in the last load session |
| chip_o | output | 1 | Most recent feedback chip |
| chip_vld_o | output | 1 | chip_o was produced by the iteration at the last edge |
| tap_o | output | 8 | XOR of the last cell's register pair |

## Verification
The hardest situation to reach is bit flow in the reverse direction through the lower registers. A bit entering at the tail needs several iterations to reach the head cell, and only tap_o and the chip stream are visible. The bench therefore seeds many random register sets and runs long stretches with run toggled. Every cycle it compares tap_o and the chip against an independent model, so an error in any cell's wiring eventually surfaces at the tail. The load session rules are reached by partial loads, repeated indices, and a load started in the middle of a run.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int DEF_CELLS = 4;
  localparam int DEF_WIDTH = 8;

  // Lowest select bit picks which register of a cell is addressed
  typedef enum logic {
    ROLE_UPPER = 1'b0,
    ROLE_LOWER = 1'b1
  } reg_role_e;
endpackage

// File: rtl/chaos_cell.sv
module chaos_cell #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             we_up_i,
  input  logic             we_lo_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] up_src_i,
  input  logic             lo_in_i,
  output logic [WIDTH-1:0] up_o,
  output logic [WIDTH-1:0] lo_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= '0;
      lo_o <= '0;
    end else begin
      if (we_up_i)     up_o <= seed_i;
      else if (step_i) up_o <= up_src_i;
      if (we_lo_i)     lo_o <= seed_i;
      else if (step_i) lo_o <= {lo_o[WIDTH-2:0], lo_in_i};
    end
  end
endmodule

// File: rtl/chaos_seed_loader.sv
module chaos_seed_loader
  import chaos_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CELLS-1:0] we_up_o,
  output logic [CELLS-1:0] we_lo_o,
  output logic             ready_o
);
  localparam int REGS = 2 * CELLS;

  logic            load_q;
  logic [REGS-1:0] seen;
  logic [REGS-1:0] hit;
  reg_role_e       role;

  assign role = reg_role_e'(sel_i[0]);
  assign hit  = {{(REGS-1){1'b0}}, 1'b1} << sel_i;

  always_comb begin
    for (int c = 0; c < CELLS; c++) begin
      we_up_o[c] = load_i && (role == ROLE_UPPER) && (int'(sel_i >> 1) == c);
      we_lo_o[c] = load_i && (role == ROLE_LOWER) && (int'(sel_i >> 1) == c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= 1'b0;
      seen    <= '0;
      ready_o <= 1'b0;
    end else begin
      load_q <= load_i;
      if (load_i) begin
        ready_o <= 1'b0;
        seen    <= (load_q ? seen : '0) | hit;
      end else begin
        ready_o <= &seen;
      end
    end
  end
endmodule

// File: rtl/chaos_chip_gen.sv
module chaos_chip_gen
  import chaos_pkg::*;
#(
  parameter int CELLS = DEF_CELLS,
  parameter int WIDTH = DEF_WIDTH,
  parameter int SEL_W = $clog2(2 * CELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             run_i,
  output logic             ready_o,
  output logic             chip_o,
  output logic             chip_vld_o,
  output logic [WIDTH-1:0] tap_o
);
  logic [CELLS-1:0] we_up, we_lo;
  logic [WIDTH-1:0] up   [CELLS];
  logic [WIDTH-1:0] lo   [CELLS];
  logic [WIDTH-1:0] mix  [CELLS];
  logic [WIDTH-1:0] usrc [CELLS];
  logic [CELLS-1:0] lin;
  logic             step;
  logic             fb_chip;

  assign step    = run_i && !load_i;
  assign fb_chip = ^mix[CELLS-1];
  assign tap_o   = mix[CELLS-1];

  chaos_seed_loader #(.CELLS(CELLS), .SEL_W(SEL_W)) u_loader (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .sel_i   (sel_i),
    .we_up_o (we_up),
    .we_lo_o (we_lo),
    .ready_o (ready_o)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign mix[c] = up[c] ^ lo[c];

    if (c == 0) begin : g_head
      assign usrc[c] = {up[c][WIDTH-2:0], fb_chip};
    end else begin : g_body
      assign usrc[c] = mix[c-1];
    end

    if (c == CELLS - 1) begin : g_tail
      assign lin[c] = fb_chip;
    end else begin : g_link
      assign lin[c] = lo[c+1][WIDTH-1];
    end

    chaos_cell #(.WIDTH(WIDTH)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step),
      .we_up_i  (we_up[c]),
      .we_lo_i  (we_lo[c]),
      .seed_i   (seed_i),
      .up_src_i (usrc[c]),
      .lo_in_i  (lin[c]),
      .up_o     (up[c]),
      .lo_o     (lo[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_o     <= 1'b0;
      chip_vld_o <= 1'b0;
    end else begin
      chip_vld_o <= step;
      if (step) chip_o <= fb_chip;
    end
  end
endmodule

// File: rtl/chaos_chip_gen_chk.sv
module chaos_chip_gen_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic             run_i,
  input logic             ready_o,
  input logic             chip_o,
  input logic             chip_vld_o,
  input logic [WIDTH-1:0] tap_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (tap_o == '0 && !ready_o && !chip_vld_o && !chip_o));

  // R4
  load_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !ready_o);

  // R3
  ready_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> !$past(load_i));

  // R5
  load_priority_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !chip_vld_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> ($stable(tap_o) && $stable(chip_o) && !chip_vld_o));

  // R9
  chip_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i) |=> (chip_vld_o && chip_o == ^$past(tap_o)));
endmodule

bind chaos_chip_gen chaos_chip_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .run_i      (run_i),
  .ready_o    (ready_o),
  .chip_o     (chip_o),
  .chip_vld_o (chip_vld_o),
  .tap_o      (tap_o)
);

// File: tb/chaos_chip_gen_test.sv
`timescale 1ns/1ps
module chaos_chip_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] seed = '0;
  logic       run = 1'b0;
  logic       ready, chip, vld;
  logic [7:0] tap;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mu [4];
  logic [7:0] ml [4];
  logic [7:0] m_seen;
  logic       m_loadq, m_ready, m_chip, m_vld;
  logic [31:0] rs = 32'h1234_5678;

  always #10 clk = ~clk;

  chaos_chip_gen uut (
    .clk(clk), .rst(rst), .load_i(load), .sel_i(sel), .seed_i(seed),
    .run_i(run), .ready_o(ready), .chip_o(chip), .chip_vld_o(vld), .tap_o(tap)
  );

  function automatic logic [31:0] nextr();
    rs = rs * 32'd1103515245 + 32'd12345;
    return rs;
  endfunction

  task automatic model_edge();
    logic [7:0] nu [4];
    logic [7:0] nl [4];
    logic fb;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin mu[i] = 0; ml[i] = 0; end
      m_seen = 0; m_loadq = 0; m_ready = 0; m_chip = 0; m_vld = 0;
      return;
    end
    if (load) begin
      if (sel[0]) ml[sel/2] = seed; else mu[sel/2] = seed;
      m_seen = (m_loadq ? m_seen : 8'h00) | (8'h01 << sel);
      m_ready = 0;
      m_vld = 0;
    end else begin
      m_ready = (m_seen == 8'hFF);
      if (run) begin
        fb = ^(mu[3] ^ ml[3]);
        for (int i = 0; i < 4; i++) begin
          nu[i] = (i == 0) ? ((mu[0] << 1) | 8'(fb)) : (mu[i-1] ^ ml[i-1]);
          nl[i] = (ml[i] << 1) | 8'((i == 3) ? fb : ml[i+1][7]);
        end
        for (int i = 0; i < 4; i++) begin mu[i] = nu[i]; ml[i] = nl[i]; end
        m_chip = fb;
        m_vld = 1;
      end else begin
        m_vld = 0;
      end
    end
    m_loadq = load;
  endtask

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "ready_o", 8'(ready), 8'(m_ready));
    check(tag, "chip_o", 8'(chip), 8'(m_chip));
    check(tag, "chip_vld_o", 8'(vld), 8'(m_vld));
    check(tag, "tap_o", tap, mu[3] ^ ml[3]);
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] v, string tag);
    load = 1; sel = s; seed = v;
    cyc(tag);
  endtask

  task automatic seed_set(logic [7:0] last);
    logic [7:0] vals [8];
    vals = '{8'hFE, 8'hFD, 8'hFC, 8'hFB, 8'hFA, 8'hF9, 8'hF8, last};
    for (int k = 0; k < 8; k++) wr(3'(k), vals[k], "R2");
    load = 0; run = 0;
    cyc("R3");
  endtask

  logic seq_a [64];
  initial begin
    int diff;
    for (int i = 0; i < 4; i++) begin mu[i] = 0; ml[i] = 0; end
    m_seen = 0; m_loadq = 0; m_ready = 0; m_chip = 0; m_vld = 0;
    @(negedge clk);
    rst = 1;
    repeat (3) cyc("R1");
    rst = 0;
    cyc("R1");

    // partial session: five registers, ready must stay low (R3)
    wr(3'd0, 8'h81, "R2"); wr(3'd3, 8'h42, "R2"); wr(3'd5, 8'h24, "R2");
    wr(3'd6, 8'h18, "R2"); wr(3'd7, 8'h99, "R2");
    load = 0;
    repeat (3) cyc("R3");
    run = 1;
    repeat (10) cyc("R8");

    // full session with a repeat index and scrambled order
    for (int k = 7; k >= 0; k--) wr(3'(k), 8'(8'h11 * k + 3), "R2");
    wr(3'd2, 8'h5A, "R2");
    load = 0; run = 0;
    repeat (2) cyc("R3");

    // run with toggled enable
    for (int n = 0; n < 60; n++) begin
      run = (n % 3) != 1;
      cyc(run ? "R7" : "R6");
    end

    // load while running: load wins, ready drops (R4, R5)
    run = 1;
    wr(3'd1, 8'hC3, "R5");
    wr(3'd4, 8'h3C, "R4");
    load = 0;
    repeat (20) cyc("R9");

    // many random seeds, long runs
    for (int s = 0; s < 40; s++) begin
      for (int k = 0; k < 8; k++) wr(3'(k), 8'(nextr() >> 16), "R2");
      load = 0;
      for (int n = 0; n < 150; n++) begin
        run = (nextr() >> 20) % 5 != 0;
        cyc(run ? "R8" : "R6");
      end
    end

    // divergence of nearly equal seeds (R10)
    seed_set(8'hF6);
    run = 1;
    for (int n = 0; n < 64; n++) begin cyc("R10"); seq_a[n] = chip; end
    seed_set(8'hF7);
    run = 1;
    diff = 0;
    for (int n = 0; n < 64; n++) begin cyc("R10"); if (chip != seq_a[n]) diff++; end
    checks++;
    if (diff == 0) begin
      errors++;
      $display("FAIL R10 differing chips actual=%0d expected=>0", diff);
    end

    // reset in the middle of a run (R1)
    rst = 1;
    cyc("R1");
    rst = 0; run = 0;
    cyc("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule